// File: doc/BRIEF.md
# SHA-512 Two-Round Compression Step

This block advances a SHA-512 working state by two compression rounds for each accepted request. The eight 64-bit working variables arrive split across two 256-bit operands. One operand carries A, B, E and F, and the other carries C, D, G and H. A 128-bit operand supplies the two word-plus-constant values, one for each round. The caller computes those values beforehand, because the block expands no message schedule and holds no constant table.

The block is iterative and runs one round per clock. A request is made by raising `start` for one cycle while the unit is idle. The block captures the inputs at that edge and runs the first round at once. The second round runs on the next edge, and `done` pulses in that cycle. The output carries the new A, B, E and F packed in lane order. It keeps that value until the next accepted request. A caller chaining a full compression swaps the operand roles between steps, as the packing implies.

Top module: `sha2r_step`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done` goes to 0 and `result` goes to all zeros. Both stay there until a request is accepted.
- R2: On an accepted request, A = `abef_in[255:192]`, B = `abef_in[191:128]`, E = `abef_in[127:64]`, F = `abef_in[63:0]`, C = `cdgh_in[255:192]`, D = `cdgh_in[191:128]`, G = `cdgh_in[127:64]` and H = `cdgh_in[63:0]`.
- R3: Each round forms T = Ch(E,F,G) + S1(E) + WK + H. The new A is T + Maj(A,B,C) + S0(A), and the new E is D + T. Ch = (E&F)^(~E&G) and Maj = (A&B)^(A&C)^(B&C). S0 is the XOR of rotate-right by 28, 34 and 39, and S1 is the XOR of rotate-right by 14, 18 and 41. Every sum wraps modulo 2^64.
- R4: The first round uses WK = `wk_in[63:0]` and the second round uses WK = `wk_in[127:64]`, both captured at acceptance.
- R5: Each round also moves B←A, C←B, D←C, F←E, G←F and H←G.
- R6: When `done` is high, `result` = {A, B, E, F} after two rounds. A is in bits 255:192, B in 191:128, E in 127:64 and F in 63:0.
- R7: A request is accepted when `start` is high at an edge and the unit is idle. `done` is then high for exactly one cycle, in the second cycle after the one in which `start` was sampled.
- R8: Once a request is accepted, later changes to the inputs do not alter its result. After `done`, `result` holds until the next accepted request.
- R9: A `start` that is high in the cycle after an accepted request is ignored. It produces no extra `done` and does not disturb the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a two-round step |
| abef_in | input | 256 | Working variables A, B, E, F |
| cdgh_in | input | 256 | Working variables C, D, G, H |
| wk_in | input | 128 | Word-plus-constant for round 0 (low) and round 1 (high) |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | 256 | New A, B, E, F after two rounds |

## Verification
The step is tried with the standard SHA-512 initial hash values and the first two round constants. Because every lane differs, that case exposes any swapped lane or misplaced word-plus-constant value. All-zero and all-ones states are also used. The all-ones case forces carries out of every sum, which separates wrapping adds from truncation slips, and the zero case isolates the WK path. Random states follow, some issued back to back on the `done` cycle and some with `start` held into the busy cycle or inputs scrambled after acceptance. These show whether the capture, the ignore rule and the hold behaviour are right.

// File: rtl/sha2r_pkg.sv
// Package sha2r_pkg: shared word and state types, the SHA-512 round
// primitive functions, and the lane unpack/pack helpers.
// Assumes 64-bit words; the rotate amounts are fixed for that width.
package sha2r_pkg;
    localparam int WORD_W  = 64;
    localparam int LANES   = 4;
    localparam int OPND_W  = LANES * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a, b, c, d, e, f, g, h;
    } wstate_t;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t bsig0(input word_t x);
        return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
    endfunction

    function automatic word_t bsig1(input word_t x);
        return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
    endfunction

    function automatic word_t choose(input word_t e, input word_t f, input word_t g);
        return (e & f) ^ (~e & g);
    endfunction

    function automatic word_t major(input word_t a, input word_t b, input word_t c);
        return (a & b) ^ (a & c) ^ (b & c);
    endfunction

    // Lane k occupies bits 64k+63:64k; lane 3 is A/C, lane 0 is F/H.
    function automatic wstate_t unpack(input logic [OPND_W-1:0] abef,
                                       input logic [OPND_W-1:0] cdgh);
        wstate_t s;
        s.a = abef[3*WORD_W +: WORD_W];
        s.b = abef[2*WORD_W +: WORD_W];
        s.e = abef[1*WORD_W +: WORD_W];
        s.f = abef[0*WORD_W +: WORD_W];
        s.c = cdgh[3*WORD_W +: WORD_W];
        s.d = cdgh[2*WORD_W +: WORD_W];
        s.g = cdgh[1*WORD_W +: WORD_W];
        s.h = cdgh[0*WORD_W +: WORD_W];
        return s;
    endfunction

    function automatic logic [OPND_W-1:0] pack(input wstate_t s);
        return {s.a, s.b, s.e, s.f};
    endfunction
endpackage

// File: rtl/sha2r_round.sv
// Module sha2r_round: one combinational SHA-512 compression round.
// Assumes the caller supplies the word-plus-constant value for this round.
module sha2r_round
    import sha2r_pkg::*;
(
    input  wstate_t cur,
    input  word_t   wk,
    output wstate_t nxt
);
    word_t t1;

    // Compute the shared term, the two new variables and the shifts.
    always_comb begin
        t1    = choose(cur.e, cur.f, cur.g) + bsig1(cur.e) + wk + cur.h;
        nxt.a = t1 + major(cur.a, cur.b, cur.c) + bsig0(cur.a);
        nxt.b = cur.a;
        nxt.c = cur.b;
        nxt.d = cur.c;
        nxt.e = cur.d + t1;
        nxt.f = cur.e;
        nxt.g = cur.f;
        nxt.h = cur.g;
    end
endmodule

// File: rtl/sha2r_seq.sv
// Module sha2r_seq: round sequencer. Accepts start only when idle, counts
// the remaining rounds and pulses done as the last round is written.
// Assumes ROUNDS >= 2.
module sha2r_seq #(
    parameter int ROUNDS = 2,
    localparam int CW    = $clog2(ROUNDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          accept,
    output logic          busy,
    output logic [CW-1:0] ridx,
    output logic          done
);
    logic [CW-1:0] rem_q;

    assign busy   = (rem_q != '0);
    assign accept = start && !busy;
    // Round index: 0 on the accept edge, then counts up with each round.
    assign ridx   = accept ? '0 : CW'(ROUNDS) - rem_q;

    // Load the round count on accept and count it down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)       rem_q <= '0;
        else if (accept)  rem_q <= CW'(ROUNDS - 1);
        else if (busy)    rem_q <= rem_q - 1'b1;
    end

    // Pulse done on the edge that writes the final round.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (rem_q == CW'(1));
    end
endmodule

// File: rtl/sha2r_step.sv
// Module sha2r_step: two SHA-512 rounds per request, one round per clock.
// Unpacks A,B,E,F and C,D,G,H from fixed lanes, captures both WK words,
// and presents the packed new A,B,E,F, held until the next request.
module sha2r_step
    import sha2r_pkg::*;
#(
    parameter int ROUNDS = 2,
    localparam int WK_W  = ROUNDS * WORD_W,
    localparam int CW    = $clog2(ROUNDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPND_W-1:0] abef_in,
    input  logic [OPND_W-1:0] cdgh_in,
    input  logic [WK_W-1:0]   wk_in,
    output logic              done,
    output logic [OPND_W-1:0] result
);
    logic          accept, busy;
    logic [CW-1:0] ridx;
    logic [WK_W-1:0] wk_q;
    wstate_t       st_q, rnd_in, rnd_out;
    word_t         wk_sel;

    sha2r_seq #(.ROUNDS(ROUNDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .accept(accept), .busy(busy), .ridx(ridx), .done(done)
    );

    // Pick the round input: fresh operands on accept, else the held state.
    always_comb begin
        rnd_in = accept ? unpack(abef_in, cdgh_in) : st_q;
        wk_sel = accept ? wk_in[WORD_W-1:0] : wk_q[int'(ridx)*WORD_W +: WORD_W];
    end

    sha2r_round u_round (.cur(rnd_in), .wk(wk_sel), .nxt(rnd_out));

    // Capture the WK words so later input changes cannot reach the step.
    always_ff @(posedge clk) begin
        if (!rst_n)      wk_q <= '0;
        else if (accept) wk_q <= wk_in;
    end

    // Write the working state once per round; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)              st_q <= '0;
        else if (accept || busy) st_q <= rnd_out;
    end

    assign result = pack(st_q);
endmodule

// File: rtl/sha2r_chk.sv
// Module sha2r_chk: protocol checks for sha2r_step, bound to every instance.
// Assumes the default of two rounds per request.
module sha2r_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [255:0] result
);
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> ##1 done);                                  // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R7
    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));                                           // R7
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);                                                 // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));                          // R8
endmodule

bind sha2r_step sha2r_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .result(result)
);

// File: tb/sim_sha2r_step.sv
// Bench sim_sha2r_step: a driver pushes expected results and done cycles
// into queues; a monitor pops and compares whenever done is seen.
module sim_sha2r_step;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] abef_in = '0, cdgh_in = '0;
    logic [127:0] wk_in = '0;
    logic         done;
    logic [255:0] result;

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 0;
    logic [255:0] exp_q[$];
    int           cyc_q[$];
    logic [255:0] last_exp = '0;

    sha2r_step u0 (.clk(clk), .rst_n(rst_n), .start(start), .abef_in(abef_in),
                   .cdgh_in(cdgh_in), .wk_in(wk_in), .done(done), .result(result));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] rr(input logic [63:0] x, input int n);
        return (x >> n) | (x << (64 - n));
    endfunction

    // Independent two-round model written from the requirements.
    function automatic logic [255:0] model(input logic [255:0] p, input logic [255:0] q,
                                           input logic [127:0] w);
        logic [63:0] a, b, c, d, e, f, g, h, t, na, ne;
        a = p[255:192]; b = p[191:128]; e = p[127:64]; f = p[63:0];
        c = q[255:192]; d = q[191:128]; g = q[127:64]; h = q[63:0];
        for (int n = 0; n < 2; n++) begin
            t  = ((e & f) ^ (~e & g)) + (rr(e,14) ^ rr(e,18) ^ rr(e,41)) + w[n*64 +: 64] + h;
            na = t + ((a & b) ^ (a & c) ^ (b & c)) + (rr(a,28) ^ rr(a,34) ^ rr(a,39));
            ne = d + t;
            h = g; g = f; f = e; e = ne; d = c; c = b; b = a; a = na;
        end
        return {a, b, e, f};
    endfunction

    function automatic logic [63:0] r64();
        return {$urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Driver: issue one request at a falling edge; optionally hold start
    // into the busy cycle and scramble the inputs after acceptance.
    task automatic issue(input logic [255:0] p, input logic [255:0] q,
                         input logic [127:0] w, input bit hold_start, input bit scramble);
        abef_in = p; cdgh_in = q; wk_in = w; start = 1'b1;
        exp_q.push_back(model(p, q, w));
        cyc_q.push_back(cyc + 2);
        last_exp = model(p, q, w);
        @(negedge clk);
        start = hold_start;
        if (scramble || hold_start) begin
            abef_in = {r64(), r64(), r64(), r64()};
            cdgh_in = {r64(), r64(), r64(), r64()};
            wk_in   = {r64(), r64()};
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: compare each done against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", 256'(done), 256'(0));
            end else begin
                check(cyc == cyc_q[0], "R7 done cycle", 256'(cyc), 256'(cyc_q[0]));
                check(result == exp_q[0], "R2 R3 R4 R5 R6 result", result, exp_q[0]);
                void'(exp_q.pop_front());
                void'(cyc_q.pop_front());
            end
        end
    end

    task automatic idle_hold(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!done, "R7 done stays low", 256'(done), 256'(0));
            check(result == last_exp, "R8 result held", result, last_exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) if (cyc > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=20000", cyc);
        finish_run();
    end

    initial begin
        logic [255:0] iv_abef, iv_cdgh;
        iv_abef = {64'h6a09e667f3bcc908, 64'hbb67ae8584caa73b,
                   64'h510e527fade682d1, 64'h9b05688c2b3e6c1f};
        iv_cdgh = {64'h3c6ef372fe94f82b, 64'ha54ff53a5f1d36f1,
                   64'h1f83d9abfb41bd6b, 64'h5be0cd19137e2179};
        repeat (3) @(negedge clk);
        check(!done, "R1 reset done", 256'(done), 256'(0));
        check(result == '0, "R1 reset result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(result == '0, "R1 result after reset", result, '0);

        // Standard initial values with the first two round constants.
        issue(iv_abef, iv_cdgh, {64'h7137449123ef65cd, 64'h428a2f98d728ae22}, 0, 0);
        idle_hold(3);
        // All zeros isolates the WK path; all ones forces wrap-around.
        issue('0, '0, {64'h0000000000000002, 64'h0000000000000001}, 0, 1);
        idle_hold(2);
        issue('1, '1, '1, 0, 1);
        idle_hold(2);
        // R9: start held into the busy cycle with different inputs.
        issue(iv_cdgh, iv_abef, {r64(), r64()}, 1, 0);
        idle_hold(3);
        // Random states, some back to back on the done cycle.
        for (int k = 0; k < 12; k++) begin
            issue({r64(), r64(), r64(), r64()}, {r64(), r64(), r64(), r64()},
                  {r64(), r64()}, 0, k[0]);
            if (k % 3 == 2) idle_hold(2);
        end
        idle_hold(3);
        check(exp_q.size() == 0, "R7 all results seen", 256'(exp_q.size()), 256'(0));
        finish_run();
    end
endmodule